// File: doc/BRIEF.md
# USB Device Interrupt Flag Controller

This block gathers the event pulses of a USB device protocol engine into sticky interrupt flags. Each endpoint has its own group of seven flags. A separate group of three flags covers bus-wide conditions: start of frame, suspend and wake-up. Software masks the flags with one enable bit per endpoint and one enable bit per global flag. Two master enables then gate the sum of the enabled flags into a single interrupt request. The request carries a two-bit priority level, which the CPU interrupt arbiter uses.

Every flag is set by hardware and cleared by software through a write-one-to-clear register port. There are two exceptions. The stall flag is also cleared by hardware when a SETUP packet arrives on the same endpoint. The wake-up flag can be set only after a suspend has been seen. Reads come from a combinational read port and have no side effects.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. This covers all flags, enables, the control register, the ping-pong mask and the isochronous mask. `irq` is 0 and `irq_level` is 00.
- R2: An event pulse on endpoint e sets bit b of the flag register at address e, and the bit reads back one clock edge later. The bit positions are: IN accepted b0, OUT stored in bank 0 b1, OUT stored in bank 1 b2, SETUP received b3, NAK on IN b4, NAK on OUT b5, STALL sent b6.
- R3: The bank-1 OUT flag (b2) is set only when bit e of the ping-pong mask (address 0x14) is 1. Otherwise the event is ignored.
- R4: The stall flag (b6) is set only when bit e of the isochronous mask (address 0x15) is 0. A SETUP event on that endpoint clears the stall flag. If a SETUP event and a STALL event arrive in the same cycle, the stall flag ends up set.
- R5: Flags clear only when software writes a 1 to their bit position. Writing 0 leaves a flag unchanged. The NAK flags have no hardware clear.
- R6: If a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R7: The global flag register at address 0x11 has three bits. A start-of-frame pulse sets b0. A suspend pulse sets b1.
- R8: A resume pulse sets the wake-up flag (b2 of 0x11) only if a suspend pulse came after the last resume. A resume with no suspend before it has no effect.
- R9: `irq` is 1 exactly when all three conditions hold: the global enable (bit 0 of 0x13) is 1, the USB enable (bit 1 of 0x13) is 1, and at least one flag is pending under its enable. An endpoint flag counts when its bit in 0x10 is 1. A global flag counts when the same bit position in 0x12 is 1.
- R10: `irq_level` equals {bit 3, bit 2} of 0x13. Level 00 is the lowest and 11 is the highest.
- R11: Reading any address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in_ack | input | N_EP | IN packet accepted by host, one bit per endpoint |
| ev_out_b0 | input | N_EP | OUT packet stored in bank 0 |
| ev_out_b1 | input | N_EP | OUT packet stored in bank 1 |
| ev_setup | input | N_EP | SETUP packet accepted |
| ev_nak_in | input | N_EP | NAK handshake on IN |
| ev_nak_out | input | N_EP | NAK handshake on OUT |
| ev_stall | input | N_EP | STALL handshake sent at software request |
| ev_sof | input | 1 | Start-of-frame packet received |
| ev_suspend | input | 1 | Bus suspend detected |
| ev_resume | input | 1 | Bus resume detected |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |
| irq_level | output | 2 | Priority level of the request |

## Verification
Each flag and configuration register takes effect at the first clock edge after its event pulse or write. The read port and `irq` are combinational from those registers, so each result is due one edge after its stimulus. The bench drives inputs on falling edges. It samples `rdata`, `irq` and `irq_level` at the next falling edge, one edge after the stimulus, with no extra wait. Cases where two causes meet in the same cycle are driven within a single falling-edge window, so that both land on the same edge.

// File: rtl/usbirq_pkg.sv
// Package usbirq_pkg
// Shared constants of the USB interrupt flag controller: register
// addresses, flag bit positions and the control register layout.
// Assumes at most 8 endpoints, so that endpoint masks fit one byte.
package usbirq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int EPF_W  = 7;
    localparam int GLF_W  = 3;

    // endpoint flag bit positions
    localparam int B_TXDONE = 0;
    localparam int B_RXB0   = 1;
    localparam int B_RXB1   = 2;
    localparam int B_SETUP  = 3;
    localparam int B_NAKIN  = 4;
    localparam int B_NAKOUT = 5;
    localparam int B_STALL  = 6;

    // fixed register addresses (endpoint flags use 0 .. N_EP-1)
    localparam logic [ADDR_W-1:0] A_EP_IEN   = 5'h10;
    localparam logic [ADDR_W-1:0] A_GLB_FLG  = 5'h11;
    localparam logic [ADDR_W-1:0] A_GLB_IEN  = 5'h12;
    localparam logic [ADDR_W-1:0] A_CTRL     = 5'h13;
    localparam logic [ADDR_W-1:0] A_PINGPONG = 5'h14;
    localparam logic [ADDR_W-1:0] A_ISO      = 5'h15;

    typedef struct packed {
        logic prio_hi;
        logic prio_lo;
        logic usb_en;
        logic glb_en;
    } ctrl_t;
endpackage

// File: rtl/usbirq_ep_flags.sv
// Module usbirq_ep_flags
// One bank of seven sticky flags per endpoint. Hardware events set the
// flags. Software write-one-to-clear and the SETUP event (stall flag only)
// clear them, and a set wins over a clear in the same cycle.
// Assumes event inputs are single-cycle pulses in the clk domain.
module usbirq_ep_flags
    import usbirq_pkg::*;
#(
    parameter int N_EP = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_EP-1:0]            ev_in_ack,
    input  logic [N_EP-1:0]            ev_out_b0,
    input  logic [N_EP-1:0]            ev_out_b1,
    input  logic [N_EP-1:0]            ev_setup,
    input  logic [N_EP-1:0]            ev_nak_in,
    input  logic [N_EP-1:0]            ev_nak_out,
    input  logic [N_EP-1:0]            ev_stall,
    input  logic [N_EP-1:0]            pingpong,
    input  logic [N_EP-1:0]            iso,
    input  logic [N_EP-1:0][EPF_W-1:0] sw_clr,
    output logic [N_EP-1:0][EPF_W-1:0] flags
);
    for (genvar e = 0; e < N_EP; e++) begin : g_ep
        logic [EPF_W-1:0] set_v;
        logic [EPF_W-1:0] clr_v;

        // gather the hardware set and clear terms for this endpoint
        always_comb begin
            set_v           = '0;
            set_v[B_TXDONE] = ev_in_ack[e];
            set_v[B_RXB0]   = ev_out_b0[e];
            set_v[B_RXB1]   = ev_out_b1[e] & pingpong[e];
            set_v[B_SETUP]  = ev_setup[e];
            set_v[B_NAKIN]  = ev_nak_in[e];
            set_v[B_NAKOUT] = ev_nak_out[e];
            set_v[B_STALL]  = ev_stall[e] & ~iso[e];
            clr_v           = sw_clr[e];
            clr_v[B_STALL]  = sw_clr[e][B_STALL] | ev_setup[e];
        end

        // flag register: clear first, then the set terms override
        always_ff @(posedge clk) begin
            if (!rst_n) flags[e] <= '0;
            else        flags[e] <= (flags[e] & ~clr_v) | set_v;
        end

        // R3
        bank1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[e][B_RXB1]) |-> $past(ev_out_b1[e] && pingpong[e]));
        // R4
        stall_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[e][B_STALL]) |-> $past(ev_stall[e] && !iso[e]));
        // R4
        stall_setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_setup[e] && !ev_stall[e]) |=> !flags[e][B_STALL]);
        // R6
        nak_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_nak_in[e] |=> flags[e][B_NAKIN]);
        // R5
        nak_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[e][B_NAKOUT]) |-> $past(sw_clr[e][B_NAKOUT]));
    end
endmodule

// File: rtl/usbirq_glb_flags.sv
// Module usbirq_glb_flags
// Bus-wide flags: start of frame, suspend and wake-up. The wake-up flag
// is armed by a suspend pulse and disarmed by the next resume pulse.
// Assumes single-cycle event pulses; a set wins over a software clear.
module usbirq_glb_flags
    import usbirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_sof,
    input  logic             ev_suspend,
    input  logic             ev_resume,
    input  logic [GLF_W-1:0] sw_clr,
    output logic [GLF_W-1:0] flags
);
    logic             armed;
    logic [GLF_W-1:0] set_v;

    // set terms for the three global flags
    assign set_v = {ev_resume & armed, ev_suspend, ev_sof};

    // suspend state tracker that arms the wake-up flag
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= 1'b0;
        else if (ev_suspend) armed <= 1'b1;
        else if (ev_resume)  armed <= 1'b0;
    end

    // sticky flag register, with set over clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~sw_clr) | set_v;
    end

    // R8
    wake_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(ev_resume && armed));
    // R7
    sof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sof |=> flags[0]);
endmodule

// File: rtl/usbirq_cfg_regs.sv
// Module usbirq_cfg_regs
// Software-written configuration: endpoint and global enables, the
// control register (master enables and priority) and the endpoint type
// masks. Assumes N_EP <= DATA_W.
module usbirq_cfg_regs
    import usbirq_pkg::*;
#(
    parameter int N_EP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_EP-1:0]   ep_ien,
    output logic [GLF_W-1:0]  glb_ien,
    output ctrl_t             ctrl,
    output logic [N_EP-1:0]   pingpong,
    output logic [N_EP-1:0]   iso
);
    // write decode into the configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_ien   <= '0;
            glb_ien  <= '0;
            ctrl     <= '0;
            pingpong <= '0;
            iso      <= '0;
        end else if (wr_en) begin
            case (addr)
                A_EP_IEN:   ep_ien   <= wdata[N_EP-1:0];
                A_GLB_IEN:  glb_ien  <= wdata[GLF_W-1:0];
                A_CTRL:     ctrl     <= wdata[3:0];
                A_PINGPONG: pingpong <= wdata[N_EP-1:0];
                A_ISO:      iso      <= wdata[N_EP-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/usb_irq_ctrl.sv
// Module usb_irq_ctrl
// Top of the USB interrupt flag controller. It decodes write-one-to-clear
// strobes, drives the combinational read port and forms the gated
// interrupt request with its two-bit priority level.
// Assumes N_EP <= 8 and addresses 0 .. N_EP-1 hold the endpoint flags.
module usb_irq_ctrl
    import usbirq_pkg::*;
#(
    parameter int N_EP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EP-1:0]   ev_in_ack,
    input  logic [N_EP-1:0]   ev_out_b0,
    input  logic [N_EP-1:0]   ev_out_b1,
    input  logic [N_EP-1:0]   ev_setup,
    input  logic [N_EP-1:0]   ev_nak_in,
    input  logic [N_EP-1:0]   ev_nak_out,
    input  logic [N_EP-1:0]   ev_stall,
    input  logic              ev_sof,
    input  logic              ev_suspend,
    input  logic              ev_resume,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic [1:0]        irq_level
);
    localparam int PAD_EP = DATA_W - N_EP;
    localparam int PAD_F  = DATA_W - EPF_W;
    localparam int PAD_G  = DATA_W - GLF_W;

    logic [N_EP-1:0][EPF_W-1:0] ep_flags;
    logic [N_EP-1:0][EPF_W-1:0] ep_clr;
    logic [GLF_W-1:0]           glb_flags;
    logic [GLF_W-1:0]           glb_clr;
    logic [N_EP-1:0]            ep_ien;
    logic [GLF_W-1:0]           glb_ien;
    ctrl_t                      ctrl;
    logic [N_EP-1:0]            pingpong;
    logic [N_EP-1:0]            iso;
    logic [N_EP-1:0]            ep_pend;

    // write-one-to-clear strobes and per-endpoint pending terms
    for (genvar e = 0; e < N_EP; e++) begin : g_clr
        assign ep_clr[e]  = (wr_en && addr == ADDR_W'(e)) ? wdata[EPF_W-1:0] : '0;
        assign ep_pend[e] = ep_ien[e] & (|ep_flags[e]);
    end
    assign glb_clr = (wr_en && addr == A_GLB_FLG) ? wdata[GLF_W-1:0] : '0;

    usbirq_ep_flags #(.N_EP(N_EP)) u_ep (
        .clk(clk), .rst_n(rst_n),
        .ev_in_ack(ev_in_ack), .ev_out_b0(ev_out_b0), .ev_out_b1(ev_out_b1),
        .ev_setup(ev_setup), .ev_nak_in(ev_nak_in), .ev_nak_out(ev_nak_out),
        .ev_stall(ev_stall), .pingpong(pingpong), .iso(iso),
        .sw_clr(ep_clr), .flags(ep_flags)
    );

    usbirq_glb_flags u_glb (
        .clk(clk), .rst_n(rst_n),
        .ev_sof(ev_sof), .ev_suspend(ev_suspend), .ev_resume(ev_resume),
        .sw_clr(glb_clr), .flags(glb_flags)
    );

    usbirq_cfg_regs #(.N_EP(N_EP)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ep_ien(ep_ien), .glb_ien(glb_ien), .ctrl(ctrl),
        .pingpong(pingpong), .iso(iso)
    );

    // combined request, gated by both master enables
    always_comb begin
        irq       = ctrl.glb_en & ctrl.usb_en &
                    ((|ep_pend) | (|(glb_flags & glb_ien)));
        irq_level = {ctrl.prio_hi, ctrl.prio_lo};
    end

    // read multiplexer, free of side effects
    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(N_EP)) begin
            for (int e = 0; e < N_EP; e++)
                if (addr == ADDR_W'(e)) rdata = {{PAD_F{1'b0}}, ep_flags[e]};
        end else begin
            case (addr)
                A_EP_IEN:   rdata = {{PAD_EP{1'b0}}, ep_ien};
                A_GLB_FLG:  rdata = {{PAD_G{1'b0}}, glb_flags};
                A_GLB_IEN:  rdata = {{PAD_G{1'b0}}, glb_ien};
                A_CTRL:     rdata = {4'b0, ctrl};
                A_PINGPONG: rdata = {{PAD_EP{1'b0}}, pingpong};
                A_ISO:      rdata = {{PAD_EP{1'b0}}, iso};
                default:    rdata = '0;
            endcase
        end
    end

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.glb_en && ctrl.usb_en));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && irq_level == 2'b00));
endmodule

// File: tb/usb_irq_ctrl_tb.sv
`timescale 1ns/1ps
module usb_irq_ctrl_tb_top;
    localparam int N_EP = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N_EP-1:0] ev_in_ack = '0, ev_out_b0 = '0, ev_out_b1 = '0, ev_setup = '0;
    logic [N_EP-1:0] ev_nak_in = '0, ev_nak_out = '0, ev_stall = '0;
    logic            ev_sof = 1'b0, ev_suspend = 1'b0, ev_resume = 1'b0;
    logic            wr_en = 1'b0;
    logic [4:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            irq;
    logic [1:0]      irq_level;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    usb_irq_ctrl #(.N_EP(N_EP)) dut_i (.*);

    // vector: {ep[2:0], ev[6:0], pp, iso, expected flags[6:0]}
    localparam logic [18:0] VEC [11] = '{
        {3'd0, 7'h01, 1'b0, 1'b0, 7'h01},  // R2 IN accepted
        {3'd1, 7'h02, 1'b0, 1'b0, 7'h02},  // R2 bank0
        {3'd2, 7'h04, 1'b1, 1'b0, 7'h04},  // R3 bank1, ping-pong
        {3'd3, 7'h04, 1'b0, 1'b0, 7'h00},  // R3 bank1 ignored
        {3'd4, 7'h08, 1'b0, 1'b0, 7'h08},  // R2 setup
        {3'd5, 7'h10, 1'b0, 1'b0, 7'h10},  // R2 nak in
        {3'd6, 7'h20, 1'b0, 1'b0, 7'h20},  // R2 nak out
        {3'd0, 7'h40, 1'b0, 1'b0, 7'h40},  // R4 stall
        {3'd1, 7'h40, 1'b0, 1'b1, 7'h00},  // R4 stall on iso ignored
        {3'd2, 7'h48, 1'b0, 1'b0, 7'h48},  // R4 setup+stall same cycle
        {3'd3, 7'h07, 1'b1, 1'b0, 7'h07}   // R2 multiple events
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_ep(input int ep, input logic [6:0] ev);
        @(negedge clk);
        ev_in_ack[ep] = ev[0]; ev_out_b0[ep] = ev[1]; ev_out_b1[ep] = ev[2];
        ev_setup[ep]  = ev[3]; ev_nak_in[ep] = ev[4]; ev_nak_out[ep] = ev[5];
        ev_stall[ep]  = ev[6];
        @(negedge clk);
        ev_in_ack = '0; ev_out_b0 = '0; ev_out_b1 = '0; ev_setup = '0;
        ev_nak_in = '0; ev_nak_out = '0; ev_stall = '0;
    endtask

    task automatic pulse_glb(input logic s, input logic p, input logic r);
        @(negedge clk);
        ev_sof = s; ev_suspend = p; ev_resume = r;
        @(negedge clk);
        ev_sof = 1'b0; ev_suspend = 1'b0; ev_resume = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 22; a++) begin
            rd(5'(a), v);
            chk("R1", v, 8'h00);
        end
        chk("R1", {6'b0, irq_level}, 8'h00);
        chk("R1", {7'b0, irq}, 8'h00);

        // R8 resume without prior suspend does nothing
        pulse_glb(1'b0, 1'b0, 1'b1);
        rd(5'h11, v); chk("R8", v, 8'h00);

        // vector table walk
        foreach (VEC[i]) begin
            logic [2:0] ep; logic [6:0] ev, ex; logic pp, is;
            {ep, ev, pp, is, ex} = VEC[i];
            wr(5'h14, 8'(pp) << ep);
            wr(5'h15, 8'(is) << ep);
            wr(5'(ep), 8'h7F);
            pulse_ep(int'(ep), ev);
            rd(5'(ep), v);
            chk("R2/R3/R4 vector", v, {1'b0, ex});
        end

        // R4 setup clears an earlier stall
        wr(5'h15, 8'h00); wr(5'h00, 8'h7F);
        pulse_ep(0, 7'h40);
        pulse_ep(0, 7'h08);
        rd(5'h00, v); chk("R4", v, 8'h08);

        // R5 write 0 keeps, write 1 clears
        wr(5'h01, 8'h7F);
        pulse_ep(1, 7'h10);
        wr(5'h01, 8'h00);
        rd(5'h01, v); chk("R5", v, 8'h10);
        wr(5'h01, 8'h10);
        rd(5'h01, v); chk("R5", v, 8'h00);

        // R6 set and clear in the same cycle
        wr(5'h02, 8'h7F);
        @(negedge clk);
        ev_nak_in[2] = 1'b1; wr_en = 1'b1; addr = 5'h02; wdata = 8'h7F;
        @(negedge clk);
        ev_nak_in = '0; wr_en = 1'b0;
        rd(5'h02, v); chk("R6", v, 8'h10);

        // R7 start of frame and suspend
        pulse_glb(1'b1, 1'b0, 1'b0);
        rd(5'h11, v); chk("R7", v, 8'h01);
        pulse_glb(1'b0, 1'b1, 1'b0);
        rd(5'h11, v); chk("R7", v, 8'h03);
        // R8 armed resume sets wake-up, then disarms
        pulse_glb(1'b0, 1'b0, 1'b1);
        rd(5'h11, v); chk("R8", v, 8'h07);
        wr(5'h11, 8'h07);
        pulse_glb(1'b0, 1'b0, 1'b1);
        rd(5'h11, v); chk("R8", v, 8'h00);

        // R9 gating: ep2 holds the NAK-in flag
        wr(5'h10, 8'h04);
        wr(5'h13, 8'h01);
        chk("R9 usb_en off", {7'b0, irq}, 8'h00);
        wr(5'h13, 8'h03);
        chk("R9 both on", {7'b0, irq}, 8'h01);
        wr(5'h10, 8'h00);
        chk("R9 ep disabled", {7'b0, irq}, 8'h00);
        pulse_glb(1'b1, 1'b0, 1'b0);
        chk("R9 sof not enabled", {7'b0, irq}, 8'h00);
        wr(5'h12, 8'h01);
        chk("R9 sof enabled", {7'b0, irq}, 8'h01);

        // R10 priority level
        wr(5'h13, 8'h07);
        chk("R10", {6'b0, irq_level}, 8'h01);
        wr(5'h13, 8'h0B);
        chk("R10", {6'b0, irq_level}, 8'h02);
        wr(5'h13, 8'h0F);
        chk("R10", {6'b0, irq_level}, 8'h03);

        // R11 reads have no side effects
        @(negedge clk);
        rd(5'h02, v);
        @(negedge clk);
        rd(5'h02, v2);
        chk("R11", v2, v);
        chk("R11", v2, 8'h10);
        rd(5'h11, v); chk("R11", v, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule